// File: doc/BRIEF.md
# Infrared SIR Pulse Encoder

This block turns the serial NRZ transmit stream of a UART into the short return-to-zero pulses used by serial infrared links. It shares the UART's 16x oversampling tick. A strobe marks the first tick of every bit period. On that strobe the block samples the NRZ level. For a logic-0 bit it drives one active-high pulse that lasts a fixed number of oversampling ticks, three by default, which is 3/16 of a bit. For a logic-1 bit it drives nothing. Idle and stop bits are logic 1, so they never light the emitter. A zero character therefore gives nine pulses: one for the start bit and one for each data bit.

The block sits between the UART serializer and the optical transceiver. When the encoder is switched off, a configuration input selects the output. The output either follows the inverted NRZ line, so the UART can drive a plain wired link, or it is held inactive. The output comes from a flip-flop, so the pulse line is free of glitches.

Top module: `irda_sir_encoder`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, `ir_pulse` is 0.
- R2: When `bit_start` is high with `enc_en` high and `nrz_tx` low (a logic-0 bit), `ir_pulse` is 1 from the next cycle.
- R3: A pulse lasts exactly PULSE_TICKS tick periods. `ir_pulse` returns to 0 in the cycle after the PULSE_TICKS-th `os_tick` that follows the starting strobe. With ticks every D clocks, it is high for PULSE_TICKS*D cycles.
- R4: When `bit_start` is high with `enc_en` high and `nrz_tx` high (a logic-1 bit), `ir_pulse` stays 0 for the whole bit period.
- R5: `nrz_tx` is sampled only in a `bit_start` cycle. Changes of `nrz_tx` between strobes change neither the width of a pulse nor whether a pulse occurs.
- R6: With `enc_en` low and `dis_follow` high, `ir_pulse` equals the inverse of `nrz_tx` one cycle later.
- R7: With `enc_en` low and `dis_follow` low, `ir_pulse` is 0 from the next cycle.
- R8: Dropping `enc_en` during a pulse ends it in the next cycle. Raising `enc_en` again in the middle of a bit starts no pulse until a later `bit_start` that sees a logic 0.
- R9: When a `bit_start` falls in the same cycle as the tick that would end a pulse, the new bit decides. A logic 0 keeps `ir_pulse` high and starts a fresh window of PULSE_TICKS ticks. A logic 1 lets the pulse end as usual.
- R10: A framed character (start bit 0, eight data bits LSB first, stop bit 1) gives one pulse per zero bit. For 0x00 that is 9 pulses; for 0xA5 it is 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_en | input | 1 | Encoder enable |
| dis_follow | input | 1 | When disabled: 1 = output follows inverted NRZ, 0 = output held at 0 |
| nrz_tx | input | 1 | NRZ transmit bit from the serializer (1 = idle/mark) |
| os_tick | input | 1 | One-cycle 16x oversampling tick |
| bit_start | input | 1 | One-cycle strobe on the first tick of each bit period |
| ir_pulse | output | 1 | Active-high pulse to the optical transmitter |

## Verification
A new bit strobe can land in the same cycle as the tick that ends the running pulse. This happens if the strobe period is shortened to PULSE_TICKS ticks. The bench produces this by issuing two strobes three ticks apart. It judges the result by whether the output stays high without a gap into a second full-width window, or falls on schedule when the second bit is a 1. A second collision is a disable arriving while a pulse is running. The bench drops the enable part way through a pulse and expects the output to fall the next cycle. It then re-enables mid-bit and expects no pulse.

// File: rtl/irp_pkg.sv
package irp_pkg;
  // Output behaviour while the encoder is switched off
  typedef enum logic {
    DIS_QUIET  = 1'b0,
    DIS_FOLLOW = 1'b1
  } irp_dis_mode_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/irp_bit_gate.sv
module irp_bit_gate (
  input  logic enc_en,
  input  logic bit_start,
  input  logic nrz_tx,
  output logic fire
);
  // A pulse is requested only for a logic-0 bit seen on the strobe
  always_comb fire = enc_en & bit_start & ~nrz_tx;
endmodule

// File: rtl/irp_width_timer.sv
module irp_width_timer #(
  parameter int unsigned PULSE_TICKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic enc_en,
  input  logic fire,
  input  logic os_tick,
  output logic active_nxt,
  output logic active_q
);
  localparam int unsigned CW = irp_pkg::cnt_width(PULSE_TICKS);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_TICKS);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] left_q, left_nxt;

  always_comb begin
    active_nxt = active_q;
    left_nxt   = left_q;
    if (!enc_en) begin
      active_nxt = 1'b0;
      left_nxt   = '0;
    end else if (fire) begin
      active_nxt = 1'b1;
      left_nxt   = LOAD;
    end else if (active_q && os_tick) begin
      if (left_q == ONE) begin
        active_nxt = 1'b0;
        left_nxt   = '0;
      end else begin
        left_nxt = left_q - ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      left_q   <= '0;
    end else begin
      active_q <= active_nxt;
      left_q   <= left_nxt;
    end
  end

  // Independent count of ticks seen since the last pulse start
  logic [CW:0] seen_q;
  always_ff @(posedge clk) begin
    if (rst || fire) seen_q <= '0;
    else if (active_q && os_tick && seen_q <= (CW+1)'(PULSE_TICKS)) seen_q <= seen_q + 1'b1;
  end

  // R3
  width_bound_chk: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (seen_q < (CW+1)'(PULSE_TICKS)));

  // R3
  fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(active_q) |-> $past(os_tick || !enc_en));
endmodule

// File: rtl/irp_out_stage.sv
module irp_out_stage (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   enc_en,
  input  irp_pkg::irp_dis_mode_e dis_mode,
  input  logic                   nrz_tx,
  input  logic                   active_nxt,
  output logic                   ir_pulse
);
  logic out_nxt;

  always_comb begin
    if (enc_en)                             out_nxt = active_nxt;
    else if (dis_mode == irp_pkg::DIS_FOLLOW) out_nxt = ~nrz_tx;
    else                                    out_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) ir_pulse <= 1'b0;
    else     ir_pulse <= out_nxt;
  end

  // R6
  follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!enc_en && dis_mode == irp_pkg::DIS_FOLLOW) |=> (ir_pulse == !$past(nrz_tx)));

  // R7
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!enc_en && dis_mode == irp_pkg::DIS_QUIET) |=> !ir_pulse);
endmodule

// File: rtl/irda_sir_encoder.sv
module irda_sir_encoder #(
  parameter int unsigned PULSE_TICKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic enc_en,
  input  logic dis_follow,
  input  logic nrz_tx,
  input  logic os_tick,
  input  logic bit_start,
  output logic ir_pulse
);
  import irp_pkg::*;

  logic          fire, active_nxt, active_q;
  irp_dis_mode_e dis_mode;

  always_comb dis_mode = dis_follow ? DIS_FOLLOW : DIS_QUIET;

  irp_bit_gate u_gate (
    .enc_en    (enc_en),
    .bit_start (bit_start),
    .nrz_tx    (nrz_tx),
    .fire      (fire)
  );

  irp_width_timer #(.PULSE_TICKS(PULSE_TICKS)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .enc_en     (enc_en),
    .fire       (fire),
    .os_tick    (os_tick),
    .active_nxt (active_nxt),
    .active_q   (active_q)
  );

  irp_out_stage u_out (
    .clk        (clk),
    .rst        (rst),
    .enc_en     (enc_en),
    .dis_mode   (dis_mode),
    .nrz_tx     (nrz_tx),
    .active_nxt (active_nxt),
    .ir_pulse   (ir_pulse)
  );

  // R2
  zero_starts_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_start && enc_en && !nrz_tx) |=> ir_pulse);

  // R4
  one_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_start && enc_en && nrz_tx) |=> !ir_pulse);

  // R1
  reset_low_chk: assert property (@(posedge clk)
    $past(rst) |-> !ir_pulse);

  // R8
  enc_active_chk: assert property (@(posedge clk) disable iff (rst)
    (enc_en && $past(enc_en) && $rose(ir_pulse)) |-> $past(bit_start && !nrz_tx));
endmodule

// File: tb/irda_sir_encoder_bench.sv
module irda_sir_encoder_bench;
  localparam int DIV = 4;          // clocks per oversampling tick
  localparam int PT  = 3;          // ticks per pulse
  localparam int BITC = 16 * DIV;  // clocks per bit

  logic clk = 1'b0, rst = 1'b1;
  logic enc_en = 1'b0, dis_follow = 1'b0, nrz_tx = 1'b1;
  logic os_tick = 1'b0, bit_start = 1'b0;
  logic ir_pulse;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irda_sir_encoder #(.PULSE_TICKS(PT)) u_irda_sir_encoder (
    .clk(clk), .rst(rst), .enc_en(enc_en), .dis_follow(dis_follow),
    .nrz_tx(nrz_tx), .os_tick(os_tick), .bit_start(bit_start), .ir_pulse(ir_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One bit period with a strobe on index 0; observations at indices 1..BITC
  task automatic send_bit(input bit v, input bit flip, output int hc, output int first, output int last);
    hc = 0; first = -1; last = -1;
    for (int i = 0; i <= BITC; i++) begin
      @(negedge clk);
      if (i > 0 && ir_pulse) begin
        hc++;
        if (first < 0) first = i;
        last = i;
      end
      if (i < BITC) begin
        enc_en    = 1'b1;
        os_tick   = (i % DIV == 0);
        bit_start = (i == 0);
        nrz_tx    = (i == 0) ? v : (flip ? ~v : v);
      end else begin
        os_tick = 1'b0; bit_start = 1'b0; nrz_tx = 1'b1;
      end
    end
  endtask

  task automatic t_reset;
    enc_en = 1'b0; dis_follow = 1'b1; nrz_tx = 1'b0;
    repeat (3) @(negedge clk);
    check(ir_pulse == 1'b0, "R1 output during reset", ir_pulse, 0);
    rst = 1'b0; nrz_tx = 1'b1; enc_en = 1'b1;
    @(negedge clk);
    check(ir_pulse == 1'b0, "R1 output after reset", ir_pulse, 0);
  endtask

  task automatic t_zero_bit;
    int hc, f, l;
    send_bit(1'b0, 1'b0, hc, f, l);
    check(f == 1, "R2 pulse start cycle", f, 1);
    check(hc == PT*DIV, "R3 pulse width", hc, PT*DIV);
    check(l == PT*DIV, "R3 pulse end cycle", l, PT*DIV);
  endtask

  task automatic t_one_bit;
    int hc, f, l;
    send_bit(1'b1, 1'b0, hc, f, l);
    check(hc == 0, "R4 one bit no pulse", hc, 0);
  endtask

  task automatic t_mid_change;
    int hc, f, l;
    send_bit(1'b0, 1'b1, hc, f, l);
    check(hc == PT*DIV, "R5 zero then line high mid-bit", hc, PT*DIV);
    send_bit(1'b1, 1'b1, hc, f, l);
    check(hc == 0, "R5 one then line low mid-bit", hc, 0);
  endtask

  task automatic t_disabled(input bit follow);
    bit pat [8] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
    @(negedge clk);
    enc_en = 1'b0; dis_follow = follow; os_tick = 1'b0; bit_start = 1'b0;
    for (int k = 0; k < 8; k++) begin
      nrz_tx = pat[k];
      bit_start = (k == 2);   // strobe has no effect while off
      @(negedge clk);
      if (follow) check(ir_pulse == ~pat[k], "R6 follows inverted NRZ", ir_pulse, ~pat[k]);
      else        check(ir_pulse == 1'b0, "R7 held inactive", ir_pulse, 0);
    end
    bit_start = 1'b0; nrz_tx = 1'b1; enc_en = 1'b1; dis_follow = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_abort;
    int hc = 0, l = -1;
    dis_follow = 1'b0;
    for (int i = 0; i <= 24; i++) begin
      @(negedge clk);
      if (i > 0 && ir_pulse) begin hc++; l = i; end
      os_tick   = (i % DIV == 0) && i < 24;
      bit_start = (i == 0);
      nrz_tx    = (i < 24) ? 1'b0 : 1'b1;
      enc_en    = !(i >= 6 && i < 10);
    end
    os_tick = 1'b0; bit_start = 1'b0;
    check(l == 6, "R8 abort on disable", l, 6);
    check(hc == 6, "R8 no restart mid-bit", hc, 6);
  endtask

  task automatic t_collide(input bit second, input int exp_hc);
    int hc = 0, l = -1;
    bit gap = 1'b0;
    for (int i = 0; i <= 40; i++) begin
      @(negedge clk);
      if (i > 0) begin
        if (ir_pulse) begin hc++; l = i; if (i > 1 && !gap && hc != i) gap = 1'b1; end
      end
      enc_en    = 1'b1;
      os_tick   = (i % DIV == 0) && i < 40;
      bit_start = (i == 0) || (i == PT*DIV);
      nrz_tx    = (i < PT*DIV) ? 1'b0 : ((i == PT*DIV) ? second : 1'b1);
    end
    os_tick = 1'b0; bit_start = 1'b0; nrz_tx = 1'b1;
    check(hc == exp_hc, "R9 strobe on ending tick width", hc, exp_hc);
    check(!gap && l == exp_hc, "R9 strobe on ending tick continuity", l, exp_hc);
  endtask

  task automatic t_frame(input logic [7:0] ch, input int exp_p);
    int hc, f, l, pulses = 0;
    logic [9:0] fr = {1'b1, ch, 1'b0};
    for (int b = 0; b < 10; b++) begin
      send_bit(fr[b], 1'b0, hc, f, l);
      if (hc == PT*DIV) pulses++;
    end
    check(pulses == exp_p, $sformatf("R10 pulses for 0x%02h", ch), pulses, exp_p);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog all-R actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_zero_bit();
    t_one_bit();
    t_mid_change();
    t_disabled(1'b1);
    t_disabled(1'b0);
    t_abort();
    t_collide(1'b0, 2*PT*DIV);
    t_collide(1'b1, PT*DIV);
    t_frame(8'h00, 9);
    t_frame(8'hA5, 5);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule